// File: doc/BRIEF.md
# Fixed-Frame Packet Padder

This block sits on a 64-bit valid/ready stream and turns packets of varying length into frames of one fixed size. The first word of every packet states the packet's size in bytes. The block forwards the packet words unchanged. It then appends filler words until the frame holds the programmed number of words, and it marks the final word of each frame with `out_last`.

The frame size is a runtime input counted in 64-bit words. It is sampled together with a synchronous clear. A packet that would not fit in the frame is never forwarded. Instead the block enters a halted state and raises a sticky error. While halted it swallows all further input and emits nothing until clear is pulsed. The packet boundary is taken from the length field alone, and only one packet is in flight at a time.

Top module: `frame_padder`

## Requirements
- R1: The packet size is the byte count in `in_data[31:16]` of the first word, and it includes that word. The packet spans ceil(bytes/8) words, with a minimum of one word, so 8 bytes is one word and 13 bytes is two.
- R2: Every output frame carries exactly `frame_words` words. `out_last` is high on the final word of each frame and on no other word.
- R3: Packet words leave the block unchanged and in their arrival order.
- R4: Each filler word is 64'hFFFF_FFFF_FFFF_FFFF.
- R5: When a packet is exactly `frame_words` long, no filler follows it and `out_last` is on its last word. This includes a frame of one word.
- R6: When a packet is longer than `frame_words` (even by one word), none of its words is output and `oversize_err` goes high.
- R7: `oversize_err` stays high, and all input is accepted and discarded with no output, until `clr` is pulsed. The clear returns the block to waiting for a header and takes the new `frame_words`.
- R8: `in_ready` is low while filler words are offered.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold steady.
- R10: After reset, `out_valid` and `oversize_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear; restarts framing and drops the error |
| frame_words | input | 16 | Frame size in 64-bit words; change only with `clr` |
| in_data | input | 64 | Input stream data |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted |
| out_data | output | 64 | Output stream data |
| out_last | output | 1 | Final word of the current frame |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream can take a word |
| oversize_err | output | 1 | Sticky oversize error |

## Verification
The hardest case to reach is a filler word or packet word stalled under backpressure while the frame boundary is close. A second hard case is a packet arriving while the block is halted, which must vanish without trace. The bench drives `out_ready` from a random pattern across back-to-back packets, so stalls land on headers, body words, filler and final words alike. It also sends packets after an oversize header and confirms that nothing reaches the scoreboard and that the error persists until the clear.

// File: rtl/padder_pkg.sv
// Shared types for the fixed-frame padder.
package padder_pkg;
    typedef enum logic [1:0] {
        ST_HEAD = 2'd0,   // waiting for the first word of a packet
        ST_BODY = 2'd1,   // forwarding remaining packet words
        ST_FILL = 2'd2,   // emitting filler until the frame is complete
        ST_HALT = 2'd3    // oversize seen; discard until clear
    } pad_state_t;
endpackage

// File: rtl/pad_len_decode.sv
// Converts a byte count from the header into a word count and flags
// packets that exceed the frame. Assumes WORD_BYTES is a power of two.
module pad_len_decode #(
    parameter int LEN_W      = 16,
    parameter int CNT_W      = 16,
    parameter int WORD_BYTES = 8
) (
    input  logic [LEN_W-1:0] len_bytes,
    input  logic [CNT_W-1:0] frame_words,
    output logic [CNT_W-1:0] pkt_words,
    output logic             too_long
);
    localparam int SHIFT = $clog2(WORD_BYTES);

    logic [LEN_W-1:0] whole;
    logic             partial;

    // Round the byte count up to whole words, never below one word.
    always_comb begin
        whole   = len_bytes >> SHIFT;
        partial = |len_bytes[SHIFT-1:0];
        if (len_bytes == '0)
            pkt_words = CNT_W'(1);
        else
            pkt_words = CNT_W'(whole) + CNT_W'(partial);
        too_long = (pkt_words > frame_words);
    end
endmodule

// File: rtl/pad_out_mux.sv
// Selects between pass-through data and the all-ones filler word.
module pad_out_mux #(
    parameter int DATA_W = 64
) (
    input  logic              fill_sel,
    input  logic [DATA_W-1:0] in_data,
    output logic [DATA_W-1:0] out_data
);
    // Drive filler or forwarded data.
    always_comb out_data = fill_sel ? {DATA_W{1'b1}} : in_data;
endmodule

// File: rtl/pad_ctrl.sv
// Framing state machine: counts words placed in the current frame and
// words left in the current packet, and derives the handshakes and
// out_last. Assumes frame_words only changes together with clr.
module pad_ctrl
    import padder_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] frame_words,
    input  logic [CNT_W-1:0] pkt_words,
    input  logic             too_long,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             out_valid,
    output logic             out_last,
    input  logic             out_ready,
    output logic             fill_sel,
    output logic             halted
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    pad_state_t       state;
    logic [CNT_W-1:0] pos;      // words already sent in this frame
    logic [CNT_W-1:0] remain;   // packet words still to come, incl. current

    // Handshake and last generation for the current state.
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_last  = 1'b0;
        fill_sel  = 1'b0;
        unique case (state)
            ST_HEAD: begin
                out_valid = in_valid && !too_long;
                in_ready  = too_long || out_ready;
                out_last  = (pkt_words == ONE) && (frame_words == ONE);
            end
            ST_BODY: begin
                out_valid = in_valid;
                in_ready  = out_ready;
                out_last  = (remain == ONE) && ((pos + ONE) == frame_words);
            end
            ST_FILL: begin
                out_valid = 1'b1;
                fill_sel  = 1'b1;
                out_last  = (pos + ONE) == frame_words;
            end
            default: in_ready = 1'b1;
        endcase
    end

    assign halted = (state == ST_HALT);

    // State and counter updates on each accepted or emitted word.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state  <= ST_HEAD;
            pos    <= '0;
            remain <= '0;
        end else begin
            unique case (state)
                ST_HEAD: if (in_valid && in_ready) begin
                    if (too_long) begin
                        state <= ST_HALT;
                    end else if (out_last) begin
                        pos <= '0;
                    end else begin
                        pos    <= ONE;
                        remain <= pkt_words - ONE;
                        state  <= (pkt_words == ONE) ? ST_FILL : ST_BODY;
                    end
                end
                ST_BODY: if (in_valid && in_ready) begin
                    remain <= remain - ONE;
                    if (out_last) begin
                        pos   <= '0;
                        state <= ST_HEAD;
                    end else begin
                        pos <= pos + ONE;
                        if (remain == ONE) state <= ST_FILL;
                    end
                end
                ST_FILL: if (out_ready) begin
                    if (out_last) begin
                        pos   <= '0;
                        state <= ST_HEAD;
                    end else begin
                        pos <= pos + ONE;
                    end
                end
                default: state <= ST_HALT;
            endcase
        end
    end

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !clr) |=> halted) else $error("halt dropped without clear"); // R7

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!out_valid && in_ready)) else $error("output while halted"); // R6

    AST_FILL_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_sel && out_valid) |-> !in_ready) else $error("input taken during fill"); // R8
endmodule

// File: rtl/frame_padder.sv
// Top level: pads each length-tagged packet on a 64-bit stream to a
// fixed number of words with all-ones filler. Assumes one packet in
// flight and a source that holds data while in_ready is low.
module frame_padder #(
    parameter int DATA_W  = 64,
    parameter int CNT_W   = 16,
    parameter int LEN_LSB = 16,
    parameter int LEN_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [CNT_W-1:0]  frame_words,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              oversize_err
);
    localparam int WORD_BYTES = DATA_W / 8;

    logic [CNT_W-1:0] pkt_words;
    logic             too_long;
    logic             fill_sel;

    pad_len_decode #(.LEN_W(LEN_W), .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES)) len_i (
        .len_bytes   (in_data[LEN_LSB +: LEN_W]),
        .frame_words (frame_words),
        .pkt_words   (pkt_words),
        .too_long    (too_long)
    );

    pad_ctrl #(.CNT_W(CNT_W)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr),
        .frame_words (frame_words),
        .pkt_words   (pkt_words),
        .too_long    (too_long),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .out_valid   (out_valid),
        .out_last    (out_last),
        .out_ready   (out_ready),
        .fill_sel    (fill_sel),
        .halted      (oversize_err)
    );

    pad_out_mux #(.DATA_W(DATA_W)) mux_i (
        .fill_sel (fill_sel),
        .in_data  (in_data),
        .out_data (out_data)
    );

    // Checker counter: words emitted since the last frame boundary.
    logic [CNT_W-1:0] chk_beats;
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            chk_beats <= '0;
        else if (out_valid && out_ready)
            chk_beats <= out_last ? '0 : chk_beats + CNT_W'(1);
    end

    AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |-> ((chk_beats + CNT_W'(1)) == frame_words))
        else $error("frame ended at wrong length"); // R2

    AST_FRAME_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |-> ((chk_beats + CNT_W'(1)) < frame_words))
        else $error("frame ran past its size"); // R2

    AST_FILL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fill_sel) |-> (out_data == {DATA_W{1'b1}}))
        else $error("filler not all ones"); // R4

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !clr) |=> (out_valid && $stable(out_data)))
        else $error("output changed under backpressure"); // R9
endmodule

// File: tb/frame_padder_tb_top.sv
`timescale 1ns/1ps
module frame_padder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic [15:0] frame_words = 16'd8;
    logic [63:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] out_data;
    logic        out_last;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        oversize_err;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int out_cnt = 0;
    int in_cnt  = 0;
    bit bp_en = 1'b0;
    bit done  = 1'b0;

    // {is_fill, last, data}
    logic [65:0] exp_q[$];

    always #10 clk = ~clk;

    frame_padder dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .frame_words(frame_words),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_last(out_last), .out_valid(out_valid),
        .out_ready(out_ready), .oversize_err(oversize_err)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Backpressure pattern, changed just after each rising edge.
    always @(posedge clk) begin
        #1 out_ready <= bp_en ? (($urandom % 3) != 0) : 1'b1;
    end

    // Scoreboard monitor, sampling mid-cycle.
    logic        stall_prev = 1'b0;
    logic [63:0] stall_data = '0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (in_valid && in_ready) in_cnt++;
            if (stall_prev && !clr)
                check(out_valid && out_data == stall_data, "R9 hold", out_data, stall_data);
            if (out_valid && out_ready) begin
                out_cnt++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected output", out_data, 64'h0);
                end else begin
                    logic [65:0] e;
                    e = exp_q.pop_front();
                    check(out_data == e[63:0], "R3/R4 data", out_data, e[63:0]);
                    check(out_last == e[64], "R2/R5 last", {63'h0, out_last}, {63'h0, e[64]});
                    if (e[65]) check(!in_ready, "R8 ready in fill", {63'h0, in_ready}, 64'h0);
                end
            end
            stall_prev <= out_valid && !out_ready;
            stall_data <= out_data;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic logic [63:0] word_of(input int id, input int len, input int i);
        if (i == 0) return {32'h1000_0000 + 32'(id), 16'(len), 16'h0};
        return {32'h2000_0000 + 32'(id), 32'(i)};
    endfunction

    // Driver: pushes expected frame, then drives the packet words.
    task automatic send_pkt(input int len, input int id, input bit dropped);
        int n;
        int fw;
        n  = (len == 0) ? 1 : (len + 7) / 8;
        fw = int'(frame_words);
        if (!dropped) begin
            for (int i = 0; i < fw; i++) begin
                if (i < n) exp_q.push_back({1'b0, (i == fw - 1), word_of(id, len, i)});
                else       exp_q.push_back({1'b1, (i == fw - 1), 64'hFFFF_FFFF_FFFF_FFFF});
            end
        end
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_data  = word_of(id, len, i);
            do @(negedge clk); while (!in_ready);
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic do_clear(input int fw);
        @(posedge clk); #1;
        clr = 1'b1;
        frame_words = 16'(fw);
        @(posedge clk); #1;
        clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        check(!out_valid && !oversize_err, "R10 reset", {62'h0, out_valid, oversize_err}, 64'h0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // R5: exact fit, 16 words.
        do_clear(16);
        send_pkt(128, 1, 1'b0);
        drain();
        // R1/R4: short packets with fill.
        do_clear(8);
        send_pkt(40, 2, 1'b0);
        send_pkt(8, 3, 1'b0);
        send_pkt(13, 4, 1'b0);
        send_pkt(0, 5, 1'b0);
        drain();
        // R5: exact fit at 5 words and a one-word frame.
        do_clear(5);
        send_pkt(40, 6, 1'b0);
        drain();
        do_clear(1);
        send_pkt(8, 7, 1'b0);
        send_pkt(3, 8, 1'b0);
        drain();
        // R2: back-to-back under backpressure; 15 in, 24 out.
        do_clear(8);
        bp_en = 1'b1;
        out_cnt = 0;
        in_cnt = 0;
        send_pkt(40, 9, 1'b0);
        send_pkt(16, 10, 1'b0);
        send_pkt(64, 11, 1'b0);
        drain();
        check(out_cnt == 24, "R2 output words", 64'(out_cnt), 64'd24);
        check(in_cnt == 15, "R1 input words", 64'(in_cnt), 64'd15);
        send_pkt(200, 12, 1'b0 ? 1'b0 : 1'b1);
        drain();
        check(oversize_err, "R6 err on large packet", {63'h0, oversize_err}, 64'h1);
        bp_en = 1'b0;
        // R6: oversize by a single word.
        do_clear(5);
        @(negedge clk);
        check(!oversize_err, "R7 cleared", {63'h0, oversize_err}, 64'h0);
        @(posedge clk); #1;
        send_pkt(48, 13, 1'b1);
        drain();
        check(oversize_err, "R6 err by one word", {63'h0, oversize_err}, 64'h1);
        // R7: input discarded while halted, error held.
        out_cnt = 0;
        send_pkt(16, 14, 1'b1);
        repeat (10) @(posedge clk);
        #1;
        check(oversize_err, "R7 sticky", {63'h0, oversize_err}, 64'h1);
        check(out_cnt == 0, "R7 silent", 64'(out_cnt), 64'h0);
        // R7: clear with new size resumes.
        do_clear(8);
        @(negedge clk);
        check(!oversize_err, "R7 clear drops err", {63'h0, oversize_err}, 64'h0);
        @(posedge clk); #1;
        send_pkt(24, 15, 1'b0);
        drain();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule